// File: doc/BRIEF.md
# Single-Wire Frame CRC Validator

This block sits on the master side of a single-wire link and validates frames read back from a slave device. Received bits arrive one at a time with a valid strobe. A start-of-frame strobe opens a frame and captures which of two formats follows. The first format is a 64-bit identity code whose top byte is a CRC over the 56 bits below it. The second is a 72-bit memory readout whose ninth byte is a CRC over the eight bytes before it.

Every accepted bit is folded into a running CRC-8 with polynomial x^8 + x^5 + x^4 + 1. The register starts at zero and is fed least significant bit first. The stored CRC byte is folded in as well, so a frame that arrived intact leaves a zero remainder. One cycle after the final bit, the block raises a single-cycle done pulse together with a pass flag. It only reports the result. Whether to retry or to continue is left to the surrounding controller, and a failure never holds up the next frame.

Top module: `onewire_crc_check`

## Requirements
- R1: During and right after reset, `done` and `pass` are low, and no frame is open.
- R2: A `sof` pulse clears the running CRC and the bit count and opens a frame. The format is taken from `frame_sel` in that cycle: 0 selects the 64-bit identity frame and 1 selects the 72-bit memory frame. `frame_sel` has no effect in any other cycle.
- R3: Bits are taken in transmission order, byte 0 first and least significant bit first. The CRC is x^8 + x^5 + x^4 + 1 with an initial value of zero.
- R4: In a 64-bit frame, `pass` is high only when the CRC of bits 0..55 equals the byte carried in bits 56..63 (bit 56 is its LSB).
- R5: In a 72-bit frame, `pass` is high only when the CRC of bytes 0..7 equals byte 8.
- R6: `done` is high for exactly one cycle, in the cycle after the final bit of the frame is accepted. `pass` is low whenever `done` is low.
- R7: A `sof` that arrives before the current frame completes abandons that frame, and no `done` is produced for it.
- R8: Bits presented while no frame is open are ignored. This covers bits before the first `sof` and bits after a frame completes.
- R9: A `bit_vld` in the same cycle as `sof` is ignored and is not counted as a frame bit.
- R10: Cycles with `bit_vld` low neither advance the count nor change the CRC.
- R11: After a failing frame, the next `sof` is accepted at once and its frame is checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe |
| frame_sel | input | 1 | Frame format, sampled with `sof` (0: 64-bit, 1: 72-bit) |
| bit_vld | input | 1 | Received bit is valid this cycle |
| bit_dat | input | 1 | Received bit value |
| done | output | 1 | Frame complete, one-cycle pulse |
| pass | output | 1 | CRC matched, qualified by `done` |

## Verification
The hardest case to reach from the ports is a frame that looks valid but is interrupted. Examples are a second `sof` that lands partway through a correct frame, a format select that changes after `sof`, and a bit strobe that coincides with `sof`. The bench reaches each of these with directed sequences. It opens a correct frame, cuts it off or disturbs it at a chosen bit, and then sends a complete frame. It then checks that exactly one `done` appears and that the flag matches the CRC computed in the bench. Gapped bit streams and stray bits outside any frame are mixed in so that counting errors show up as missing or extra pulses.

// File: rtl/onewire_crc_check.sv
module onewire_crc_check #(
  parameter int ROM_BITS = 64,
  parameter int SCR_BITS = 72,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_REV = 8'h8C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic frame_sel,
  input  logic bit_vld,
  input  logic bit_dat,
  output logic done,
  output logic pass
);
  localparam int CNT_W = $clog2(SCR_BITS + 1);
  localparam logic [CNT_W-1:0] ROM_LAST = CNT_W'(ROM_BITS - 1);
  localparam logic [CNT_W-1:0] SCR_LAST = CNT_W'(SCR_BITS - 1);

  logic [CRC_W-1:0] crc, crc_nxt;
  logic [CNT_W-1:0] cnt;
  logic active, sel_q, take, last;

  assign take    = bit_vld & active & ~sof;
  assign last    = cnt == (sel_q ? SCR_LAST : ROM_LAST);
  assign crc_nxt = {1'b0, crc[CRC_W-1:1]} ^ ((crc[0] ^ bit_dat) ? POLY_REV : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc    <= '0;
      cnt    <= '0;
      active <= 1'b0;
      sel_q  <= 1'b0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      if (sof) begin
        crc    <= '0;
        cnt    <= '0;
        active <= 1'b1;
        sel_q  <= frame_sel;
      end else if (take) begin
        crc <= crc_nxt;
        cnt <= cnt + 1'b1;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
          pass   <= crc_nxt == '0;
        end
      end
    end
  end
endmodule

module onewire_crc_check_chk (
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic bit_vld,
  input logic done,
  input logic pass
);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  pass_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !pass);
  // R7
  sof_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n) sof |=> !done);
  // R10
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !bit_vld |=> !done);
endmodule

bind onewire_crc_check onewire_crc_check_chk chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld), .done(done), .pass(pass)
);

// File: tb/onewire_crc_check_test.sv
module onewire_crc_check_test;
  logic clk = 1'b0, rst_n = 1'b0, sof = 1'b0, frame_sel = 1'b0, bit_vld = 1'b0, bit_dat = 1'b0;
  logic done, pass;
  int vecs = 0, errs = 0, done_seen = 0;

  always #2 clk = ~clk;

  onewire_crc_check uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .frame_sel(frame_sel),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .done(done), .pass(pass)
  );

  always @(negedge clk) if (done) done_seen++;

  function automatic logic [7:0] crc8(input logic [71:0] fr, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ fr[i];
      c = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [71:0] mk_rom(input logic [55:0] body);
    return {8'h00, crc8({16'h0, body}, 56), body};
  endfunction

  function automatic logic [71:0] mk_scr(input logic [63:0] body);
    return {crc8({8'h0, body}, 64), body};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_frame(input logic sel);
    @(negedge clk); sof = 1'b1; frame_sel = sel;
    @(negedge clk); sof = 1'b0; frame_sel = ~sel;
  endtask

  task automatic send_bits(input logic [71:0] fr, input int from, input int to, input bit gaps);
    for (int i = from; i < to; i++) begin
      bit_vld = 1'b1; bit_dat = fr[i];
      @(negedge clk);
      if (gaps && i % 5 == 2) begin
        bit_vld = 1'b0; bit_dat = ~fr[i];
        repeat (2) @(negedge clk);
      end
    end
    bit_vld = 1'b0;
  endtask

  task automatic full_frame(input logic sel, input logic [71:0] fr, input bit gaps,
                            input bit exp_pass, input string req);
    int n = sel ? 72 : 64;
    int d0;
    open_frame(sel);
    d0 = done_seen;
    send_bits(fr, 0, n - 1, gaps);
    check(done_seen == d0, req, done_seen - d0, 0);
    bit_vld = 1'b1; bit_dat = fr[n-1];
    @(negedge clk); bit_vld = 1'b0;
    check(done === 1'b1, req, done, 1);
    check(pass === exp_pass, req, pass, exp_pass);
    @(negedge clk);
    check(done === 1'b0 && pass === 1'b0, {req, " R6"}, done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(done === 1'b0 && pass === 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && pass === 1'b0, "R1", pass, 0);
  endtask

  task automatic t_stray_before();
    int d0 = done_seen;
    send_bits(mk_rom(56'h0), 0, 64, 1'b0);
    repeat (2) @(negedge clk);
    check(done_seen == d0, "R8 bits before any sof", done_seen - d0, 0);
  endtask

  task automatic t_rom_good();
    full_frame(1'b0, mk_rom(56'h1234_5678_9ABC_DE), 1'b0, 1'b1, "R4 R3 good id");
    full_frame(1'b0, mk_rom(56'h0), 1'b0, 1'b1, "R4 zero id");
  endtask

  task automatic t_rom_bad();
    logic [71:0] f = mk_rom(56'h00A5_5A00_FF01_28);
    f[13] = ~f[13];
    full_frame(1'b0, f, 1'b0, 1'b0, "R4 corrupt data");
    f = mk_rom(56'h00A5_5A00_FF01_28);
    f[63] = ~f[63];
    full_frame(1'b0, f, 1'b0, 1'b0, "R4 corrupt crc");
  endtask

  task automatic t_scr();
    logic [71:0] f = mk_scr(64'h1007_FF4B_467F_5001);
    full_frame(1'b1, f, 1'b1, 1'b1, "R5 R10 gapped memory frame");
    f[70] = ~f[70];
    full_frame(1'b1, f, 1'b0, 1'b0, "R5 bad ninth byte");
    full_frame(1'b1, mk_scr(64'hDEAD_BEEF_0BAD_F00D), 1'b0, 1'b1, "R11 after fail");
  endtask

  task automatic t_abort();
    int d0 = done_seen;
    open_frame(1'b1);
    send_bits(mk_scr(64'h1), 0, 40, 1'b0);
    full_frame(1'b0, mk_rom(56'hCAFE_F00D_1234_56), 1'b0, 1'b1, "R7 restart");
    check(done_seen == d0 + 1, "R7 one done only", done_seen - d0, 1);
  endtask

  task automatic t_after_done();
    int d0 = done_seen;
    send_bits(mk_rom(56'h0), 0, 72, 1'b0);
    repeat (2) @(negedge clk);
    check(done_seen == d0, "R8 bits after completion", done_seen - d0, 0);
  endtask

  task automatic t_sel_len();
    int d0;
    logic [71:0] f = mk_rom(56'h0102_0304_0506_07);
    open_frame(1'b0);
    d0 = done_seen;
    send_bits(f, 0, 64, 1'b0);
    @(negedge clk);
    check(done_seen == d0 + 1, "R2 length from sel at sof", done_seen - d0, 1);
  endtask

  task automatic t_sof_bit();
    logic [71:0] f = mk_rom(56'h7766_5544_3322_11);
    int d0;
    @(negedge clk); sof = 1'b1; frame_sel = 1'b0; bit_vld = 1'b1; bit_dat = 1'b1;
    @(negedge clk); sof = 1'b0; bit_vld = 1'b0;
    d0 = done_seen;
    send_bits(f, 0, 63, 1'b0);
    @(negedge clk);
    check(done_seen == d0, "R9 sof-cycle bit not counted", done_seen - d0, 0);
    bit_vld = 1'b1; bit_dat = f[63];
    @(negedge clk); bit_vld = 1'b0;
    check(done === 1'b1 && pass === 1'b1, "R9 frame intact", pass, 1);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    errs++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_stray_before();
    t_rom_good();
    t_rom_bad();
    t_scr();
    t_abort();
    t_after_done();
    t_sel_len();
    t_sof_bit();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule